// File: doc/BRIEF.md
# Tapped Delay Line Hit Encoder

This block turns the registered snapshot of a 48-tap delay line into a fine time code. A hit enters the line at tap 0 and moves toward the far end. On each clock edge the block reads the tap vector and finds where the hit's leading edge sits. That position is the fine code, and the coarse cycle counter supplies the coarse timestamp. A set tap means the edge has already passed it. A clean snapshot is therefore a run of ones from tap 0 up to the front, followed by zeros.

The line is deliberately longer than one clock period, so the same edge can be caught in two successive snapshots. A capture that arrives exactly one cycle after a first capture is treated as the second sighting of the same hit. The block then emits one word that carries the coarse time of the first capture and both codes, N1 and N2. A downstream stage uses the pair to calibrate the delay per tap. When no second capture follows, the word is marked as a single capture and N2 reads zero. Snapshots with no front (all zeros), or whose front has left the line (all ones), are not captures.

Top module: `tdl_hit_encoder`

## Requirements
- R1: While reset is held, and after it, outVld, outPair, outN1, outN2 and outCoarse read zero until the first result.
- R2: The fine code of a snapshot is the lowest tap index i (1..47) at which filtered tap i-1 is 1 and filtered tap i is 0, so a clean front after p set taps gives code p.
- R3: Before encoding, every tap at index 1..46 takes the majority of itself and its two neighbours, so a single flipped tap lying at least two taps away from the front leaves the code unchanged.
- R4: An all-zero snapshot is not a capture and never produces an output word of its own.
- R5: An all-ones snapshot, where the front has passed tap 47, is not a capture and never produces an output word of its own.
- R6: A capture in the cycle directly after a first capture gives one word with outPair=1, outN1 set to the first code, outN2 set to the second code, and outCoarse set to coarseIn as sampled with the first capture.
- R7: A first capture followed by a non-capture gives one word with outPair=0, outN2=0, outN1 set to the first code and outCoarse set to the coarse count of the first capture.
- R8: A capture directly after a completed pair starts a new hit and is not paired with the pair's second capture.
- R9: outVld is a one-cycle strobe. It rises on the clock edge that samples the snapshot after the first capture, and it is never high in two consecutive cycles.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| tapIn | input | TAPS (48) | Registered tap snapshot, bit 0 is the line entry |
| coarseIn | input | CW (16) | Coarse cycle counter |
| outVld | output | 1 | One-cycle result strobe |
| outCoarse | output | CW (16) | Coarse count of the first capture |
| outN1 | output | CODEW (6) | Fine code of the first capture |
| outN2 | output | CODEW (6) | Fine code of the second capture, zero for a single |
| outPair | output | 1 | Set when N2 holds a second sighting |

## Verification
The block presents tap snapshots on the falling edge, and each one is sampled on the next rising edge. A word for a hit whose first capture was sampled on edge k is due right after edge k+1, for both the paired and the single case. The bench reads every output on the falling edge that follows each rising edge. A reference model, updated with the snapshot just driven, predicts what must appear at the next sampling point, including the cycles in which outVld has to stay low. Random fronts, bubbles and empty or full snapshots are mixed with directed cases at codes 1 and 47 and with back-to-back captures.

// File: rtl/tdl_enc_pkg.sv
`timescale 1ns/1ps
package tdl_enc_pkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic load;       // latch the current capture as a first sighting
    logic emitPair;   // emit held capture paired with the current one
    logic emitSingle; // emit held capture alone
  } encStb_t;
endpackage

// File: rtl/tdl_enc_datapath.sv
`timescale 1ns/1ps
module tdl_enc_datapath
  import tdl_enc_pkg::*;
#(
  parameter int TAPS = 48,
  parameter int CW   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [TAPS-1:0]          tapIn,
  input  logic [CW-1:0]            coarseIn,
  input  encStb_t                  stb,
  output logic                     hitValid,
  output logic                     outVld,
  output logic [CW-1:0]            outCoarse,
  output logic [$clog2(TAPS)-1:0]  outN1,
  output logic [$clog2(TAPS)-1:0]  outN2,
  output logic                     outPair
);
  localparam int CODEW = $clog2(TAPS);

  logic [TAPS-1:0]  filt;
  logic [TAPS-1:0]  fall;
  logic [CODEW-1:0] code;
  logic [CODEW-1:0] heldN1;
  logic [CW-1:0]    heldCoarse;

  // Bubble filter: interior taps take a three-tap majority
  for (genvar i = 0; i < TAPS; i++) begin : g_filt
    if (i == 0 || i == TAPS - 1) begin : g_edge
      assign filt[i] = tapIn[i];
    end else begin : g_mid
      assign filt[i] = (tapIn[i-1] & tapIn[i]) | (tapIn[i] & tapIn[i+1]) |
                       (tapIn[i-1] & tapIn[i+1]);
    end
  end

  // One-to-zero transitions mark candidate front positions
  for (genvar i = 0; i < TAPS; i++) begin : g_fall
    if (i == 0) begin : g_none
      assign fall[i] = 1'b0;
    end else begin : g_cmp
      assign fall[i] = filt[i-1] & ~filt[i];
    end
  end

  // Priority encoder: lowest transition wins
  always_comb begin
    code = '0;
    for (int i = TAPS - 1; i >= 1; i--) begin
      if (fall[i]) code = CODEW'(i);
    end
  end

  assign hitValid = |fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      heldN1     <= '0;
      heldCoarse <= '0;
    end else if (stb.load) begin
      heldN1     <= code;
      heldCoarse <= coarseIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outVld    <= 1'b0;
      outCoarse <= '0;
      outN1     <= '0;
      outN2     <= '0;
      outPair   <= 1'b0;
    end else begin
      outVld <= stb.emitPair | stb.emitSingle;
      if (stb.emitPair || stb.emitSingle) begin
        outCoarse <= heldCoarse;
        outN1     <= heldN1;
        outN2     <= stb.emitPair ? code : '0;
        outPair   <= stb.emitPair;
      end
    end
  end
endmodule

// File: rtl/tdl_enc_control.sv
`timescale 1ns/1ps
module tdl_enc_control
  import tdl_enc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    hitValid,
  output encStb_t stb
);
  logic pending;

  always_comb begin
    stb.load       = ~pending & hitValid;
    stb.emitPair   = pending & hitValid;
    stb.emitSingle = pending & ~hitValid;
  end

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= ~pending & hitValid;
  end
endmodule

// File: rtl/tdl_hit_encoder.sv
`timescale 1ns/1ps
module tdl_hit_encoder
  import tdl_enc_pkg::*;
#(
  parameter int TAPS = 48,
  parameter int CW   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [TAPS-1:0]         tapIn,
  input  logic [CW-1:0]           coarseIn,
  output logic                    outVld,
  output logic [CW-1:0]           outCoarse,
  output logic [$clog2(TAPS)-1:0] outN1,
  output logic [$clog2(TAPS)-1:0] outN2,
  output logic                    outPair
);
  encStb_t stb;
  logic    hitValid;

  tdl_enc_control u_ctrl (
    .clk(clk), .rst(rst), .hitValid(hitValid), .stb(stb)
  );

  tdl_enc_datapath #(.TAPS(TAPS), .CW(CW)) u_dp (
    .clk(clk), .rst(rst), .tapIn(tapIn), .coarseIn(coarseIn), .stb(stb),
    .hitValid(hitValid), .outVld(outVld), .outCoarse(outCoarse),
    .outN1(outN1), .outN2(outN2), .outPair(outPair)
  );
endmodule

// File: rtl/tdl_enc_checker.sv
`timescale 1ns/1ps
module tdl_enc_checker #(
  parameter int TAPS = 48,
  parameter int CW   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [TAPS-1:0]         tapIn,
  input logic                    outVld,
  input logic [$clog2(TAPS)-1:0] outN1,
  input logic [$clog2(TAPS)-1:0] outN2,
  input logic                    outPair
);
  localparam int CODEW = $clog2(TAPS);

  // R9: strobe never lasts two cycles
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    outVld |=> !outVld);

  // R2: reported first code lies on a real tap boundary
  a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
    outVld |-> (outN1 >= CODEW'(1) && outN1 <= CODEW'(TAPS - 1)));

  // R7: a single capture carries no second code
  a_r7_single_no_n2: assert property (@(posedge clk) disable iff (rst)
    (outVld && !outPair) |-> outN2 == '0);

  // R4: an empty snapshot cannot close a hit into a word two edges later
  a_r4_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (tapIn == '0) |-> ##2 !outVld);

  // R5: a fully passed snapshot behaves like no capture
  a_r5_ones_quiet: assert property (@(posedge clk) disable iff (rst)
    (tapIn == '1) |-> ##2 !outVld);
endmodule

bind tdl_hit_encoder tdl_enc_checker #(.TAPS(TAPS), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tapIn(tapIn), .outVld(outVld),
  .outN1(outN1), .outN2(outN2), .outPair(outPair)
);

// File: tb/test_tdl_hit_encoder.sv
`timescale 1ns/1ps
module test_tdl_hit_encoder;
  localparam int TAPS  = 48;
  localparam int CW    = 16;
  localparam int CODEW = $clog2(TAPS);
  localparam int STEP  = 36; // taps per clock period in the line model

  logic                 clk = 1'b0;
  logic                 rst;
  logic [TAPS-1:0]      tapIn;
  logic [CW-1:0]        coarseIn;
  logic                 outVld;
  logic [CW-1:0]        outCoarse;
  logic [CODEW-1:0]     outN1;
  logic [CODEW-1:0]     outN2;
  logic                 outPair;

  tdl_hit_encoder #(.TAPS(TAPS), .CW(CW)) i_tdl_hit_encoder (
    .clk(clk), .rst(rst), .tapIn(tapIn), .coarseIn(coarseIn),
    .outVld(outVld), .outCoarse(outCoarse), .outN1(outN1),
    .outN2(outN2), .outPair(outPair)
  );

  always #10 clk = ~clk;

  int nChk = 0, nFail = 0, cyc = 0;
  bit finished = 0;
  // reference model
  bit mPend = 0; int mN1 = 0, mCoarse = 0; string mTag = "R2";
  bit eVld = 0, ePair = 0; int eN1 = 0, eN2 = 0, eCoarse = 0;
  string eTag = "R1", eCodeTag = "R2";
  string nextTag = "";

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkOut();
    if (eVld) begin
      chk(outVld == 1'b1, eTag, "outVld", outVld, 1);
      chk(outPair == ePair, eTag, "outPair", outPair, ePair);
      chk(outN1 == eN1, eCodeTag, "outN1", outN1, eN1);
      chk(outN2 == eN2, eTag, "outN2", outN2, eN2);
      chk(outCoarse == eCoarse, eTag, "outCoarse", outCoarse, eCoarse);
    end else begin
      chk(outVld == 1'b0, eTag, "outVld idle", outVld, 0);
    end
  endtask

  function automatic logic [TAPS-1:0] thermo(int p);
    logic [TAPS-1:0] v = '0;
    for (int i = 0; i < p; i++) v[i] = 1'b1;
    return v;
  endfunction

  // kind: 0 front, 1 all zero, 2 all ones
  task automatic step(int kind, int p, int bub);
    logic [TAPS-1:0] snap;
    @(negedge clk);
    checkOut();
    if (kind == 0) begin
      snap = thermo(p);
      if (bub > 0) snap[bub] = ~snap[bub];
    end else if (kind == 1) snap = '0;
    else snap = '1;
    tapIn    = snap;
    coarseIn = CW'(cyc);
    eVld = 0;
    eTag = (kind == 1) ? "R4" : (kind == 2) ? "R5" : "R9";
    if (kind == 0) begin
      if (mPend) begin
        eVld = 1; ePair = 1; eN1 = mN1; eN2 = p; eCoarse = mCoarse;
        eTag = "R6"; eCodeTag = mTag; mPend = 0;
      end else begin
        mPend = 1; mN1 = p; mCoarse = cyc % (1 << CW);
        mTag = (bub > 0) ? "R3" : "R2";
        if (nextTag != "") begin mTag = nextTag; nextTag = ""; end
      end
    end else if (mPend) begin
      eVld = 1; ePair = 0; eN1 = mN1; eN2 = 0; eCoarse = mCoarse;
      eTag = (mTag == "R8") ? "R8" : "R7"; eCodeTag = mTag; mPend = 0;
    end
    cyc++;
  endtask

  function automatic int pickBubble(int p);
    for (int t = 0; t < 40; t++) begin
      int j = 1 + int'($urandom % 46);
      if (j <= p - 3 || j >= p + 2) return j;
    end
    return 0;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; tapIn = '0; coarseIn = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(outVld == 0 && outPair == 0, "R1", "flags in reset", {outVld, outPair}, 0);
    chk(outN1 == 0 && outN2 == 0, "R1", "codes in reset", {outN1, outN2}, 0);
    chk(outCoarse == 0, "R1", "coarse in reset", outCoarse, 0);
    rst = 1'b0;
    // directed: pair at low code then far code (R6)
    step(0, 5, 0); step(0, 5 + STEP, 0); step(1, 0, 0);
    // single at code 47 (R7, R2 upper bound)
    step(0, 47, 0); step(1, 0, 0); step(1, 0, 0);
    // code 1 then front leaves line (R5 closes as single)
    step(0, 1, 0); step(2, 0, 0); step(2, 0, 0);
    // bubble on both sides of the front (R3)
    step(0, 20, 10); step(0, 30, 40); step(1, 0, 0);
    // three consecutive captures: third starts new hit (R8)
    step(0, 10, 0); step(0, 30, 0); nextTag = "R8"; step(0, 12, 0);
    step(1, 0, 0); step(1, 0, 0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 100);
      if (r < 45) begin
        int p = 1 + int'($urandom % 47);
        int b = (($urandom % 3) == 0) ? pickBubble(p) : 0;
        step(0, p, b);
        if (p + STEP <= 47 && ($urandom % 2) == 0) step(0, p + STEP, 0);
      end else if (r < 75) step(1, 0, 0);
      else step(2, 0, 0);
    end
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    #(64'd20 * 150000);
    if (!finished) begin
      finished = 1;
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule